// File: doc/BRIEF.md
# 2D Drawing Command Planner

This block is the decode stage in front of a 2D pixel mover. Software loads eight 32-bit parameter registers through a simple write port: the two base addresses, the two corner positions, the block dimensions, the two pitches, the operation word and the pixel format word. A start strobe then makes the block decode the operation and check both rectangles against the size of local memory. It picks one of seven plans and hands the mover start byte addresses, the pixel size, the geometry and the raster-op fields. It does no memory traffic of its own.

Most plans run straight through to the mover. A reverse (right-to-left) copy whose source and destination overlap gets a plan that tells the mover to stage the block through a temporary buffer. Copies where the source and destination coincide, and copies or fills of a single pixel, are turned into short plans so the mover skips its rectangle set-up. The chosen plan is held at the outputs until the mover acknowledges it.

Top module: `blit_planner`

## Requirements
- R1: Register select 0..7 writes source base, destination base, source position, destination position, dimensions, pitch, operation word and format word. A position holds X in bits 28:16 and Y in bits 15:0. Dimensions hold width in bits 28:16 and height in bits 15:0. Pitch holds destination pitch in bits 28:16 and source pitch in bits 12:0. In the operation word, bits 20:16 are the command (0 copy, 1 fill), bit 27 is the reverse flag, bit 15 is the two-operand raster select, bit 14 is the pattern-source flag and bits 7:0 are the raster code. These four raster and direction fields appear unchanged on the outputs with the plan.
- R2: The format field is bits 21:20 of the format word. Pixel size in bytes is 1 shifted left by the format. A written format of 3 is stored with bit 20 cleared, so it acts as format 2 (4 bytes).
- R3: A non-zero value in format-word bits 19:16, or a command other than 0 or 1, yields plan 0 (reject).
- R4: On a reverse operation the positions name the bottom-right pixel. The start corner is X−(width−1), Y−(height−1). A start corner that would fall below zero is rejected (plan 0).
- R5: A rectangle is rejected (plan 0) if its base is at or above the memory size, or if base + (x + width + (y + height) × pitch) × pixel size is at or above the memory size. Fills check the destination only. Copies check both source and destination.
- R6: A copy whose source and destination have equal base, pitch, X and Y yields plan 1 (no-op).
- R7: A 1×1 copy yields plan 2 and a 1×1 fill yields plan 3. The start byte address of each side is base + (x + y × pitch) × pixel size, which holds for every accepted plan. A fill reports source address 0.
- R8: For a reverse copy with equal bases and equal pitches, the rectangles overlap when they intersect on both axes under strict comparisons. An overlapping copy yields plan 5 (staged copy).
- R9: For any other reverse copy, each side spans from its start address to start + (width + (height−1) × pitch) × pixel size. They overlap when each span starts before the other ends, which yields plan 5.
- R10: Every other copy, including any forward copy, yields plan 4 (direct copy). A larger fill yields plan 6 (rectangle fill).
- R11: A start seen while no plan is pending gives plan_valid high on the next clock edge. The plan and all its fields then hold until an edge with plan_ack high, after which plan_valid is low. busy equals plan_valid, and start is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Parameter register write strobe |
| wr_sel | input | 3 | Parameter register select |
| wr_data | input | 32 | Parameter write data |
| mem_bytes | input | ADDR_W | Local memory size in bytes |
| start | input | 1 | Decode request strobe |
| busy | output | 1 | A plan is pending |
| plan_valid | output | 1 | Plan outputs are valid |
| plan_ack | input | 1 | Mover accepts the plan |
| plan_code | output | 3 | Chosen plan, 0..6 |
| src_addr | output | ADDR_W | Source start byte address |
| dst_addr | output | ADDR_W | Destination start byte address |
| px_bytes | output | 3 | Bytes per pixel: 1, 2 or 4 |
| blk_w | output | 13 | Block width in pixels |
| blk_h | output | 16 | Block height in pixels |
| src_pitch | output | 13 | Source pitch in pixels |
| dst_pitch | output | 13 | Destination pitch in pixels |
| rop_code | output | 8 | Raster code |
| rop2_mode | output | 1 | Two-operand raster select |
| pat_src | output | 1 | Pattern is the source |
| reverse | output | 1 | Right-to-left operation |

## Verification
Each parameter write lands on the edge where wr_en is sampled. A start sampled on the next edge sees the new values and shows its whole plan on that same edge, one cycle after the strobe. plan_valid falls on the edge that samples plan_ack. The bench drives on falling edges and reads every plan field at the falling edge right after the start edge. It reads plan_valid again one falling edge after the acknowledge. A start issued while a plan is pending is followed by a check, one cycle later, that every field still holds the earlier plan.

// File: rtl/blit_pkg.sv
package blit_pkg;

  localparam int REG_W = 32;
  localparam int NREG  = 8;
  localparam int SELW  = $clog2(NREG);
  localparam int XW    = 13;
  localparam int YW    = 16;
  localparam int PW    = 13;
  localparam int WW    = 13;
  localparam int HW    = 16;

  localparam logic [SELW-1:0] SEL_SRC_BASE = 3'd0;
  localparam logic [SELW-1:0] SEL_DST_BASE = 3'd1;
  localparam logic [SELW-1:0] SEL_SRC_POS  = 3'd2;
  localparam logic [SELW-1:0] SEL_DST_POS  = 3'd3;
  localparam logic [SELW-1:0] SEL_DIMS     = 3'd4;
  localparam logic [SELW-1:0] SEL_PITCH    = 3'd5;
  localparam logic [SELW-1:0] SEL_OPWORD   = 3'd6;
  localparam logic [SELW-1:0] SEL_FMTWORD  = 3'd7;

  localparam logic [4:0] CMD_COPY = 5'd0;
  localparam logic [4:0] CMD_FILL = 5'd1;

  typedef enum logic [2:0] {
    PLAN_REJECT      = 3'd0,
    PLAN_NOOP        = 3'd1,
    PLAN_PIX_COPY    = 3'd2,
    PLAN_PIX_FILL    = 3'd3,
    PLAN_COPY        = 3'd4,
    PLAN_COPY_STAGED = 3'd5,
    PLAN_FILL        = 3'd6
  } plan_e;

  typedef struct packed {
    logic [REG_W-1:0] src_base;
    logic [REG_W-1:0] dst_base;
    logic [REG_W-1:0] src_pos;
    logic [REG_W-1:0] dst_pos;
    logic [REG_W-1:0] dims;
    logic [REG_W-1:0] pitch;
    logic [REG_W-1:0] opword;
    logic [REG_W-1:0] fmtword;
  } blit_regs_t;

endpackage

// File: rtl/blit_reg_bank.sv
module blit_reg_bank
  import blit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SELW-1:0]  wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output blit_regs_t       regs
);

  logic [REG_W-1:0] q   [NREG];
  logic [REG_W-1:0] d_fmt;

  // A format code of 3 is folded to 2 by dropping its low bit.
  always_comb begin
    d_fmt = wr_data;
    if (wr_data[21:20] == 2'b11) d_fmt[20] = 1'b0;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic             ld;
    logic [REG_W-1:0] d;
    always_comb begin
      ld = wr_en && (wr_sel == SELW'(i));
      d  = (SELW'(i) == SEL_FMTWORD) ? d_fmt : wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= '0;
      else if (ld) q[i] <= d;
    end
  end

  always_comb begin
    regs.src_base = q[SEL_SRC_BASE];
    regs.dst_base = q[SEL_DST_BASE];
    regs.src_pos  = q[SEL_SRC_POS];
    regs.dst_pos  = q[SEL_DST_POS];
    regs.dims     = q[SEL_DIMS];
    regs.pitch    = q[SEL_PITCH];
    regs.opword   = q[SEL_OPWORD];
    regs.fmtword  = q[SEL_FMTWORD];
  end

endmodule

// File: rtl/blit_span.sv
module blit_span
  import blit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CW     = ADDR_W + 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [XW-1:0]     pos_x,
  input  logic [YW-1:0]     pos_y,
  input  logic [PW-1:0]     pitch,
  input  logic [WW-1:0]     w,
  input  logic [HW-1:0]     h,
  input  logic [1:0]        fmt,
  input  logic              rtl,
  input  logic [ADDR_W-1:0] mem_bytes,
  output logic [CW-1:0]     adj_x,
  output logic [CW-1:0]     adj_y,
  output logic [CW-1:0]     start_addr,
  output logic [CW-1:0]     end_addr,
  output logic              oob
);

  logic [CW-1:0] wx, hx, px, xe, ye, be, me;
  logic [CW-1:0] w_m1, h_m1, lim_off, start_off, span_len;
  logic          under;

  always_comb begin
    wx = CW'(w);
    hx = CW'(h);
    px = CW'(pitch);
    xe = CW'(pos_x);
    ye = CW'(pos_y);
    be = CW'(base);
    me = CW'(mem_bytes);

    w_m1 = (wx == '0) ? '0 : wx - CW'(1);
    h_m1 = (hx == '0) ? '0 : hx - CW'(1);

    // reverse operations give the far corner; walk back to the near one
    under = rtl && ((xe < w_m1) || (ye < h_m1));
    adj_x = rtl ? xe - w_m1 : xe;
    adj_y = rtl ? ye - h_m1 : ye;

    lim_off    = (adj_x + wx + (adj_y + hx) * px) << fmt;
    start_off  = (adj_x + adj_y * px) << fmt;
    span_len   = (wx + h_m1 * px) << fmt;
    start_addr = be + start_off;
    end_addr   = start_addr + span_len;

    oob = under || (be >= me) || ((be + lim_off) >= me);
  end

endmodule

// File: rtl/blit_overlap.sv
module blit_overlap #(
  parameter int CW = 40
) (
  input  logic          same_geom,
  input  logic [CW-1:0] sx,
  input  logic [CW-1:0] sy,
  input  logic [CW-1:0] dx,
  input  logic [CW-1:0] dy,
  input  logic [CW-1:0] w,
  input  logic [CW-1:0] h,
  input  logic [CW-1:0] s_start,
  input  logic [CW-1:0] s_end,
  input  logic [CW-1:0] d_start,
  input  logic [CW-1:0] d_end,
  output logic          hit
);

  logic rect_hit, line_hit;

  always_comb begin
    rect_hit = (sx < dx + w) && (sx + w > dx) &&
               (sy < dy + h) && (sy + h > dy);
    line_hit = (d_start < s_end) && (s_start < d_end);
    hit      = same_geom ? rect_hit : line_hit;
  end

endmodule

// File: rtl/blit_planner.sv
module blit_planner
  import blit_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] mem_bytes,
  input  logic              start,
  output logic              busy,
  output logic              plan_valid,
  input  logic              plan_ack,
  output logic [2:0]        plan_code,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [2:0]        px_bytes,
  output logic [12:0]       blk_w,
  output logic [15:0]       blk_h,
  output logic [12:0]       src_pitch,
  output logic [12:0]       dst_pitch,
  output logic [7:0]        rop_code,
  output logic              rop2_mode,
  output logic              pat_src,
  output logic              reverse
);

  localparam int CW    = ADDR_W + 8;
  localparam int NSIDE = 2;   // 0 source, 1 destination

  blit_regs_t r;

  blit_reg_bank u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .regs    (r)
  );

  // field decode
  logic [4:0]    cmd;
  logic          rtl_f;
  logic [1:0]    fmt;
  logic [3:0]    amode;
  logic [WW-1:0] w;
  logic [HW-1:0] h;
  logic [2:0]    px;

  always_comb begin
    cmd   = r.opword[20:16];
    rtl_f = r.opword[27];
    fmt   = r.fmtword[21:20];
    amode = r.fmtword[19:16];
    w     = r.dims[28:16];
    h     = r.dims[15:0];
    px    = 3'(1) << fmt;
  end

  logic [ADDR_W-1:0] s_base  [NSIDE];
  logic [XW-1:0]     s_x     [NSIDE];
  logic [YW-1:0]     s_y     [NSIDE];
  logic [PW-1:0]     s_pitch [NSIDE];
  logic [CW-1:0]     a_x     [NSIDE];
  logic [CW-1:0]     a_y     [NSIDE];
  logic [CW-1:0]     a_beg   [NSIDE];
  logic [CW-1:0]     a_end   [NSIDE];
  logic              a_oob   [NSIDE];

  always_comb begin
    s_base[0]  = ADDR_W'(r.src_base);
    s_base[1]  = ADDR_W'(r.dst_base);
    s_x[0]     = r.src_pos[28:16];
    s_y[0]     = r.src_pos[15:0];
    s_x[1]     = r.dst_pos[28:16];
    s_y[1]     = r.dst_pos[15:0];
    s_pitch[0] = r.pitch[12:0];
    s_pitch[1] = r.pitch[28:16];
  end

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    blit_span #(.ADDR_W(ADDR_W), .CW(CW)) u_span (
      .base       (s_base[s]),
      .pos_x      (s_x[s]),
      .pos_y      (s_y[s]),
      .pitch      (s_pitch[s]),
      .w          (w),
      .h          (h),
      .fmt        (fmt),
      .rtl        (rtl_f),
      .mem_bytes  (mem_bytes),
      .adj_x      (a_x[s]),
      .adj_y      (a_y[s]),
      .start_addr (a_beg[s]),
      .end_addr   (a_end[s]),
      .oob        (a_oob[s])
    );
  end

  logic same_geom, ovl;

  always_comb begin
    same_geom = (s_base[0] == s_base[1]) && (s_pitch[0] == s_pitch[1]);
  end

  blit_overlap #(.CW(CW)) u_ovl (
    .same_geom (same_geom),
    .sx        (a_x[0]),
    .sy        (a_y[0]),
    .dx        (a_x[1]),
    .dy        (a_y[1]),
    .w         (CW'(w)),
    .h         (CW'(h)),
    .s_start   (a_beg[0]),
    .s_end     (a_end[0]),
    .d_start   (a_beg[1]),
    .d_end     (a_end[1]),
    .hit       (ovl)
  );

  // classification
  logic  is_copy, is_fill, single, reject, noop;
  plan_e plan_d;

  always_comb begin
    is_copy = (cmd == CMD_COPY);
    is_fill = (cmd == CMD_FILL);
    single  = (w == WW'(1)) && (h == HW'(1));
    reject  = (amode != 4'd0) || !(is_copy || is_fill) ||
              a_oob[1] || (is_copy && a_oob[0]);
    noop    = same_geom && (a_x[0] == a_x[1]) && (a_y[0] == a_y[1]);

    if (reject)           plan_d = PLAN_REJECT;
    else if (is_fill)     plan_d = single ? PLAN_PIX_FILL : PLAN_FILL;
    else if (noop)        plan_d = PLAN_NOOP;
    else if (single)      plan_d = PLAN_PIX_COPY;
    else if (rtl_f && ovl) plan_d = PLAN_COPY_STAGED;
    else                  plan_d = PLAN_COPY;
  end

  // plan holding register
  logic              load;
  logic              valid_q, valid_d;
  plan_e             plan_q;
  logic [ADDR_W-1:0] src_q, dst_q, src_d;
  logic [2:0]        px_q;
  logic [WW-1:0]     w_q;
  logic [HW-1:0]     h_q;
  logic [PW-1:0]     sp_q, dp_q;
  logic [7:0]        rop_q;
  logic              rop2_q, pat_q, rev_q;

  always_comb begin
    load    = start && !valid_q;
    src_d   = is_fill ? '0 : ADDR_W'(a_beg[0]);
    valid_d = valid_q;
    if (load)          valid_d = 1'b1;
    else if (plan_ack) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plan_q <= PLAN_REJECT;
      src_q  <= '0;
      dst_q  <= '0;
      px_q   <= '0;
      w_q    <= '0;
      h_q    <= '0;
      sp_q   <= '0;
      dp_q   <= '0;
      rop_q  <= '0;
      rop2_q <= 1'b0;
      pat_q  <= 1'b0;
      rev_q  <= 1'b0;
    end else if (load) begin
      plan_q <= plan_d;
      src_q  <= src_d;
      dst_q  <= ADDR_W'(a_beg[1]);
      px_q   <= px;
      w_q    <= w;
      h_q    <= h;
      sp_q   <= s_pitch[0];
      dp_q   <= s_pitch[1];
      rop_q  <= r.opword[7:0];
      rop2_q <= r.opword[15];
      pat_q  <= r.opword[14];
      rev_q  <= rtl_f;
    end
  end

  always_comb begin
    busy       = valid_q;
    plan_valid = valid_q;
    plan_code  = plan_q;
    src_addr   = src_q;
    dst_addr   = dst_q;
    px_bytes   = px_q;
    blk_w      = w_q;
    blk_h      = h_q;
    src_pitch  = sp_q;
    dst_pitch  = dp_q;
    rop_code   = rop_q;
    rop2_mode  = rop2_q;
    pat_src    = pat_q;
    reverse    = rev_q;
  end

endmodule

// File: rtl/blit_planner_chk.sv
module blit_planner_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              plan_ack,
  input logic              plan_valid,
  input logic [2:0]        plan_code,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr,
  input logic [2:0]        px_bytes,
  input logic [12:0]       blk_w,
  input logic [15:0]       blk_h,
  input logic [ADDR_W-1:0] mem_bytes
);

  a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !plan_valid) |=> plan_valid);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (plan_valid && !plan_ack) |=> (plan_valid && $stable(plan_code) &&
                                   $stable(src_addr) && $stable(dst_addr)));

  a_r11_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (plan_valid && plan_ack) |=> !plan_valid);

  a_r2_px_legal: assert property (@(posedge clk) disable iff (!rst_n)
    plan_valid |-> ($countones(px_bytes) == 1 && !px_bytes[0] || px_bytes == 3'd1));

  a_r10_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    plan_valid |-> (plan_code != 3'd7));

  a_r5_dst_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (plan_valid && plan_code >= 3'd2) |-> (dst_addr < mem_bytes));

  a_r7_pix_dims: assert property (@(posedge clk) disable iff (!rst_n)
    (plan_valid && (plan_code == 3'd2 || plan_code == 3'd3)) |->
      (blk_w == 13'd1 && blk_h == 16'd1));

  a_r6_noop_same: assert property (@(posedge clk) disable iff (!rst_n)
    (plan_valid && plan_code == 3'd1) |-> (src_addr == dst_addr));

endmodule

bind blit_planner blit_planner_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .plan_ack   (plan_ack),
  .plan_valid (plan_valid),
  .plan_code  (plan_code),
  .src_addr   (src_addr),
  .dst_addr   (dst_addr),
  .px_bytes   (px_bytes),
  .blk_w      (blk_w),
  .blk_h      (blk_h),
  .mem_bytes  (mem_bytes)
);

// File: tb/test_blit_planner.sv
`timescale 1ns/1ps
module test_blit_planner;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] mem_bytes = 32'h0001_0000;
  logic        start = 1'b0;
  logic        plan_ack = 1'b0;
  logic        busy, plan_valid;
  logic [2:0]  plan_code, px_bytes;
  logic [31:0] src_addr, dst_addr;
  logic [12:0] blk_w, src_pitch, dst_pitch;
  logic [15:0] blk_h;
  logic [7:0]  rop_code;
  logic        rop2_mode, pat_src, reverse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  blit_planner i_blit_planner (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mem_bytes(mem_bytes), .start(start), .busy(busy), .plan_valid(plan_valid),
    .plan_ack(plan_ack), .plan_code(plan_code), .src_addr(src_addr),
    .dst_addr(dst_addr), .px_bytes(px_bytes), .blk_w(blk_w), .blk_h(blk_h),
    .src_pitch(src_pitch), .dst_pitch(dst_pitch), .rop_code(rop_code),
    .rop2_mode(rop2_mode), .pat_src(pat_src), .reverse(reverse)
  );

  typedef struct packed {
    logic [31:0] sbase, dbase, spos, dpos, dims, pitch, opw, fmtw;
    logic [2:0]  plan;
    logic [31:0] esrc, edst;
    logic [2:0]  epx;
    logic        chk_addr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    // R10 forward copy, 2-byte pixels
    '{32'h0, 32'h8000, 32'h0002_0003, 32'h0004_0005, 32'h0004_0002, 32'h0010_0010,
      32'h0000_C0CC, 32'h0010_0000, 3'd4, 32'h64, 32'h80A8, 3'd2, 1'b1, 8'd10},
    // R10 rectangle fill
    '{32'h0, 32'h100, 32'h0, 32'h0001_0001, 32'h0003_0003, 32'h0008_0000,
      32'h0001_0000, 32'h0, 3'd6, 32'h0, 32'h109, 3'd1, 1'b1, 8'd10},
    // R7 single pixel fill
    '{32'h0, 32'h100, 32'h0, 32'h0001_0001, 32'h0001_0001, 32'h0008_0000,
      32'h0001_0000, 32'h0, 3'd3, 32'h0, 32'h109, 3'd1, 1'b1, 8'd7},
    // R7 single pixel copy, 4-byte pixels
    '{32'h0, 32'h200, 32'h0000_0002, 32'h0003_0000, 32'h0001_0001, 32'h0004_0004,
      32'h0, 32'h0020_0000, 3'd2, 32'h20, 32'h20C, 3'd4, 1'b1, 8'd7},
    // R6 no-op copy
    '{32'h40, 32'h40, 32'h0001_0001, 32'h0001_0001, 32'h0002_0002, 32'h0008_0008,
      32'h0, 32'h0, 3'd1, 32'h49, 32'h49, 3'd1, 1'b1, 8'd6},
    // R8 reverse copy, shared geometry, overlapping
    '{32'h0, 32'h0, 32'h0005_0005, 32'h0006_0006, 32'h0004_0004, 32'h0010_0010,
      32'h0800_0000, 32'h0, 3'd5, 32'h22, 32'h33, 3'd1, 1'b1, 8'd8},
    // R8 reverse copy, shared geometry, disjoint in X
    '{32'h0, 32'h0, 32'h0005_0005, 32'h000D_0005, 32'h0004_0004, 32'h0010_0010,
      32'h0800_0000, 32'h0, 3'd4, 32'h22, 32'h2A, 3'd1, 1'b1, 8'd8},
    // R9 reverse copy, separate bases, spans overlap
    '{32'h1000, 32'h1008, 32'h0003_0001, 32'h0003_0001, 32'h0004_0002, 32'h0010_0010,
      32'h0800_0000, 32'h0, 3'd5, 32'h1000, 32'h1008, 3'd1, 1'b1, 8'd9},
    // R9 reverse copy, separate bases, disjoint spans
    '{32'h1000, 32'h2000, 32'h0003_0001, 32'h0003_0001, 32'h0004_0002, 32'h0010_0010,
      32'h0800_0000, 32'h0, 3'd4, 32'h1000, 32'h2000, 3'd1, 1'b1, 8'd9},
    // R10 forward copy that overlaps still goes direct
    '{32'h0, 32'h0, 32'h0002_0002, 32'h0003_0003, 32'h0004_0004, 32'h0010_0010,
      32'h0, 32'h0, 3'd4, 32'h22, 32'h33, 3'd1, 1'b1, 8'd10},
    // R5 destination runs past memory end
    '{32'h0, 32'hFFF0, 32'h0, 32'h0, 32'h0004_0004, 32'h0010_0000,
      32'h0001_0000, 32'h0, 3'd0, 32'h0, 32'h0, 3'd1, 1'b0, 8'd5},
    // R5 destination base equal to memory size
    '{32'h0, 32'h1_0000, 32'h0, 32'h0, 32'h0001_0001, 32'h0010_0000,
      32'h0001_0000, 32'h0, 3'd0, 32'h0, 32'h0, 3'd1, 1'b0, 8'd5},
    // R5 source runs past memory end
    '{32'hFF00, 32'h0, 32'h0, 32'h0, 32'h0004_0004, 32'h0010_0040,
      32'h0, 32'h0, 3'd0, 32'h0, 32'h0, 3'd1, 1'b0, 8'd5},
    // R3 unsupported addressing bits
    '{32'h0, 32'h100, 32'h0, 32'h0001_0001, 32'h0003_0003, 32'h0008_0000,
      32'h0001_0000, 32'h0001_0000, 3'd0, 32'h0, 32'h0, 3'd1, 1'b0, 8'd3},
    // R3 unknown command
    '{32'h0, 32'h100, 32'h0, 32'h0001_0001, 32'h0003_0003, 32'h0008_0000,
      32'h0002_0000, 32'h0, 3'd0, 32'h0, 32'h0, 3'd1, 1'b0, 8'd3},
    // R2 format 3 folded to 4-byte pixels
    '{32'h0, 32'h0, 32'h0, 32'h0001_0000, 32'h0002_0001, 32'h0008_0000,
      32'h0001_0000, 32'h0030_0000, 3'd6, 32'h0, 32'h4, 3'd4, 1'b1, 8'd2},
    // R5 limit lands exactly on memory size
    '{32'h0, 32'hFEF0, 32'h0, 32'h0, 32'h0010_0001, 32'h0100_0000,
      32'h0001_0000, 32'h0, 3'd0, 32'h0, 32'h0, 3'd1, 1'b0, 8'd5},
    // R5 limit one byte below memory size
    '{32'h0, 32'hFEEF, 32'h0, 32'h0, 32'h0010_0001, 32'h0100_0000,
      32'h0001_0000, 32'h0, 3'd6, 32'h0, 32'hFEEF, 3'd1, 1'b1, 8'd5},
    // R4 reverse start corner below zero
    '{32'h0, 32'h0, 32'h0001_0005, 32'h000A_000A, 32'h0004_0002, 32'h0010_0010,
      32'h0800_0000, 32'h0, 3'd0, 32'h0, 32'h0, 3'd1, 1'b0, 8'd4}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input vec_t v);
    wr(3'd0, v.sbase); wr(3'd1, v.dbase); wr(3'd2, v.spos); wr(3'd3, v.dpos);
    wr(3'd4, v.dims);  wr(3'd5, v.pitch); wr(3'd6, v.opw);  wr(3'd7, v.fmtw);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic ack_plan();
    @(negedge clk); plan_ack = 1'b1;
    @(negedge clk); plan_ack = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    load(v);
    pulse_start();
    check({tag, " valid"}, 64'(plan_valid), 64'd1);
    check({tag, " plan"}, 64'(plan_code), 64'(v.plan));
    if (v.chk_addr) begin
      check({tag, " src_addr"}, 64'(src_addr), 64'(v.esrc));
      check({tag, " dst_addr"}, 64'(dst_addr), 64'(v.edst));
      check({tag, " px_bytes"}, 64'(px_bytes), 64'(v.epx));
    end
    ack_plan();
    check("R11 valid drops after ack", 64'(plan_valid), 64'd0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset valid", 64'(plan_valid), 64'd0);
    check("R11 reset busy", 64'(busy), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1 raster and direction fields on a forward copy
    load(VECS[0]);
    pulse_start();
    check("R1 rop_code", 64'(rop_code), 64'hCC);
    check("R1 rop2_mode", 64'(rop2_mode), 64'd1);
    check("R1 pat_src", 64'(pat_src), 64'd1);
    check("R1 reverse", 64'(reverse), 64'd0);
    check("R1 blk_w", 64'(blk_w), 64'd4);
    check("R1 blk_h", 64'(blk_h), 64'd2);
    check("R1 pitches", 64'({src_pitch, dst_pitch}), 64'({13'd16, 13'd16}));
    ack_plan();

    // R1 reverse flag carried out
    load(VECS[5]);
    pulse_start();
    check("R1 reverse set", 64'(reverse), 64'd1);
    ack_plan();

    // R11 start ignored while a plan is pending
    load(VECS[1]);
    pulse_start();
    check("R11 busy", 64'(busy), 64'd1);
    load(VECS[3]);
    pulse_start();
    @(negedge clk);
    check("R11 held plan", 64'(plan_code), 64'd6);
    check("R11 held dst", 64'(dst_addr), 64'h109);
    check("R11 held px", 64'(px_bytes), 64'd1);
    ack_plan();
    check("R11 idle after ack", 64'(busy), 64'd0);
    pulse_start();
    check("R11 new plan", 64'(plan_code), 64'd2);
    check("R11 new dst", 64'(dst_addr), 64'h20C);
    ack_plan();

    // R5 a smaller memory turns an accepted fill into a reject
    mem_bytes = 32'h0000_FFFF;
    load(VECS[17]);
    pulse_start();
    check("R5 smaller memory", 64'(plan_code), 64'd0);
    ack_plan();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule